// File: doc/BRIEF.md
# Configuration Register Access Hub

The hub is the single memory-mapped slave port through which configuration registers spread over several downstream register banks are reached. Two masters use it: a local processor and a maintenance engine that turns remote requests into single-word reads and writes. Arbitration between them happens outside the block. Each access carries one 32-bit word and a 17-bit byte address. The hub drops the two low address bits and splits the 15-bit word address into a 3-bit region and a 12-bit word offset. It forwards the access to the bank that owns the region, holds `s_waitreq` high until that bank signals completion, and returns read data with one `s_rvalid` pulse.

The hub also owns a small local register range with three words: an event status word, an event enable word and a read-only identity word. Five event sources feed sticky status bits. Three come from neighbouring logic on input pins: a received port-write, an I/O read out of bounds and an I/O write out of bounds. The hub raises the other two itself, for a write it refused and for a write with a bad burst count. `irq` is high whenever a status bit and its enable bit are both set.

The controller has four named states. IDLE waits for a request. BANK_WAIT drives one bank select until that bank's done. ACK drops `s_waitreq` for one cycle. RDATA pulses `s_rvalid`. The transitions are:
- IDLE→BANK_WAIT when a valid access targets a bank.
- IDLE→ACK for local, unmapped and rejected accesses.
- BANK_WAIT→ACK on the selected bank's done.
- ACK→IDLE after a write.
- ACK→RDATA after a read.
- RDATA→IDLE.

Top module: `cfg_hub`

## Requirements
- R1: Byte-address bits [1:0] have no effect; the word address is `s_addr[16:2]`, region is `s_addr[16:14]`, word offset is `s_addr[13:2]`.
- R2: Regions 0, 1 and 2 are forwarded to bank 0, 1 and 2 respectively with `b_addr` equal to the word offset; at most one bit of `b_sel` is ever high.
- R3: A bank access holds `s_waitreq` high while the bank is selected, lowers it for exactly one cycle after the bank's `b_done`, and a read then gives exactly one `s_rvalid` cycle carrying that bank's data. With a bank that raises done after k+1 selected cycles, `s_waitreq` is high for k+3 cycles; local and unmapped accesses see 1.
- R4: Region 3, which belongs to the doorbell registers, is never forwarded: no `b_sel` bit rises, reads return 0 and writes set status bit 3.
- R5: Reads of regions 4–6, or of local offsets above 2, return 0. A write there, or to the read-only identity word (region 7 offset 2), changes nothing and sets status bit 3 (refused write).
- R6: A write with `s_burst` not equal to 1 is not forwarded, leaves the target unchanged and sets status bit 4.
- R7: A one-cycle pulse on `ev_in[0]` (port-write received), `ev_in[1]` (read out of bounds) or `ev_in[2]` (write out of bounds) sets status bit 0, 1 or 2, which stays set.
- R8: Writing the status word (region 7 offset 0, byte 0x1C000) clears each status bit whose data bit is 1; an event arriving in the same cycle as the clear keeps its bit set.
- R9: `irq` is the OR over status bits that are also set in the enable word (region 7 offset 1, byte 0x1C004, bits [4:0]); a set but disabled bit leaves `irq` low.
- R10: After reset status and enable read 0, `irq` and `s_rvalid` are low, no bank is selected and `s_waitreq` is high in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_addr | input | 17 | Byte address of the access |
| s_read | input | 1 | Read request |
| s_write | input | 1 | Write request |
| s_wdata | input | 32 | Write data |
| s_burst | input | 4 | Burst count of the request |
| s_waitreq | output | 1 | Low for the cycle in which the request completes |
| s_rdata | output | 32 | Read data, valid with s_rvalid |
| s_rvalid | output | 1 | One-cycle read data strobe |
| irq | output | 1 | Enabled event interrupt |
| ev_in | input | 3 | Event pulses: port-write, read out of bounds, write out of bounds |
| b_sel | output | 3 | One-hot bank select, held until done |
| b_we | output | 1 | Bank write enable |
| b_addr | output | 12 | Word offset inside the bank |
| b_wdata | output | 32 | Bank write data |
| b_rdata | input | 96 | Read data of the banks, bank i at [32i+31:32i] |
| b_done | input | 3 | Per-bank completion |

## Verification
The bench gives the three banks different latencies. A hub that released `s_waitreq` at a fixed delay, or read the wrong bank's done, would show a wrong wait count or stale data. Misaligned addresses catch a decoder that used the low byte bits. Accesses to the doorbell region and to empty regions must select no bank, so a decoder that folded region 3 into the bank range would show selected cycles. A status clear that arrives together with a fresh event tests set-over-clear priority, and a disabled but pending bit tests that `irq` is masked. A write with a bad burst count is followed by a read-back of the target, which shows whether the write leaked through.

// File: rtl/cfg_hub_pkg.sv
package cfg_hub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BANK_WAIT,
        ST_ACK,
        ST_RDATA
    } hub_state_e;

    typedef enum logic [1:0] {
        TGT_BANK,
        TGT_LOCAL,
        TGT_NONE
    } hub_tgt_e;

    // status bit positions
    localparam int EVB_PORTWR   = 0;
    localparam int EVB_RD_OOB   = 1;
    localparam int EVB_WR_OOB   = 2;
    localparam int EVB_BAD_WR   = 3;
    localparam int EVB_BAD_BURST = 4;
    localparam int NUM_EV       = 5;
    localparam int NUM_EXT_EV   = 3;
endpackage

// File: rtl/cfg_hub_decode.sv
module cfg_hub_decode
    import cfg_hub_pkg::*;
#(
    parameter int WA     = 15,
    parameter int RGN_W  = 3,
    parameter int NB     = 3,
    parameter int DB_RGN = 3,
    parameter int LOC_RGN = 7,
    localparam int BIW   = (NB > 1) ? $clog2(NB) : 1,
    localparam int OFF_W = WA - RGN_W
) (
    input  logic [WA-1:0]    word_addr,
    output hub_tgt_e         tgt,
    output logic [BIW-1:0]   bank_idx,
    output logic [OFF_W-1:0] offset
);
    logic [RGN_W-1:0] region;

    assign region = word_addr[WA-1 -: RGN_W];
    assign offset = word_addr[OFF_W-1:0];

    always_comb begin
        tgt      = TGT_NONE;
        bank_idx = '0;
        if (int'(region) == DB_RGN) begin
            tgt = TGT_NONE;
        end else if (int'(region) == LOC_RGN) begin
            tgt = TGT_LOCAL;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (int'(region) == i) begin
                    tgt      = TGT_BANK;
                    bank_idx = BIW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/cfg_hub_events.sv
module cfg_hub_events
    import cfg_hub_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFF_W = 12,
    parameter logic [DW-1:0] ID_VALUE = 32'h5A1E_0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EXT_EV-1:0] ev_in,
    input  logic                  set_bad_wr,
    input  logic                  set_bad_burst,
    input  logic                  loc_we,
    input  logic [OFF_W-1:0]      loc_off,
    input  logic [NUM_EV-1:0]     loc_wdata,
    output logic [DW-1:0]         loc_rdata,
    output logic                  loc_wr_ok,
    output logic [NUM_EV-1:0]     sts_q,
    output logic [NUM_EV-1:0]     en_q,
    output logic [NUM_EV-1:0]     sts_clr,
    output logic                  irq
);
    localparam logic [OFF_W-1:0] OFF_STS = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_EN  = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_ID  = OFF_W'(2);

    logic [NUM_EV-1:0] sts_set;

    assign sts_set   = {set_bad_burst, set_bad_wr, ev_in};
    assign sts_clr   = (loc_we && loc_off == OFF_STS) ? loc_wdata : '0;
    assign loc_wr_ok = (loc_off == OFF_STS) || (loc_off == OFF_EN);
    assign irq       = |(sts_q & en_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_clr) | sts_set;
            if (loc_we && loc_off == OFF_EN) begin
                en_q <= loc_wdata;
            end
        end
    end

    always_comb begin
        loc_rdata = '0;
        if (loc_off == OFF_STS) begin
            loc_rdata[NUM_EV-1:0] = sts_q;
        end else if (loc_off == OFF_EN) begin
            loc_rdata[NUM_EV-1:0] = en_q;
        end else if (loc_off == OFF_ID) begin
            loc_rdata = ID_VALUE;
        end
    end
endmodule

// File: rtl/cfg_hub_fsm.sv
module cfg_hub_fsm
    import cfg_hub_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NB    = 3,
    parameter int OFF_W = 12,
    localparam int BIW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_read,
    input  logic             s_write,
    input  logic [DW-1:0]    s_wdata,
    input  logic             burst_ok,
    input  hub_tgt_e         tgt,
    input  logic [BIW-1:0]   dec_bank,
    input  logic [OFF_W-1:0] dec_off,
    input  logic [DW-1:0]    loc_rdata,
    input  logic             loc_wr_ok,
    input  logic [NB-1:0]    b_done,
    input  logic [NB*DW-1:0] b_rdata,
    output logic             s_waitreq,
    output logic             s_rvalid,
    output logic [DW-1:0]    s_rdata,
    output logic [NB-1:0]    b_sel,
    output logic             b_we,
    output logic [OFF_W-1:0] b_addr,
    output logic [DW-1:0]    b_wdata,
    output logic             loc_we,
    output logic             bad_wr,
    output logic             bad_burst
);
    hub_state_e       state_q, state_d;
    logic             lat_we;
    logic [BIW-1:0]   lat_bank;
    logic [OFF_W-1:0] lat_off;
    logic [DW-1:0]    lat_wd;
    logic [DW-1:0]    rdata_q;
    logic             req;
    logic             done_sel;
    logic [DW-1:0]    rd_sel;

    assign req = s_read || s_write;

    // pick completion and data of the latched bank
    always_comb begin
        done_sel = 1'b0;
        rd_sel   = '0;
        for (int i = 0; i < NB; i++) begin
            if (lat_bank == BIW'(i)) begin
                done_sel = b_done[i];
                rd_sel   = b_rdata[i*DW +: DW];
            end
        end
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lat_we   <= 1'b0;
            lat_bank <= '0;
            lat_off  <= '0;
            lat_wd   <= '0;
            rdata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                lat_we   <= s_write;
                lat_bank <= dec_bank;
                lat_off  <= dec_off;
                lat_wd   <= s_wdata;
                rdata_q  <= (tgt == TGT_LOCAL) ? loc_rdata : '0;
            end else if (state_q == ST_BANK_WAIT && done_sel) begin
                rdata_q  <= rd_sel;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (s_write && !burst_ok)  state_d = ST_ACK;
                    else if (tgt == TGT_BANK)  state_d = ST_BANK_WAIT;
                    else                       state_d = ST_ACK;
                end
            end
            ST_BANK_WAIT: if (done_sel) state_d = ST_ACK;
            ST_ACK:       state_d = lat_we ? ST_IDLE : ST_RDATA;
            ST_RDATA:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_waitreq = (state_q != ST_ACK);
        s_rvalid  = (state_q == ST_RDATA);
        s_rdata   = rdata_q;
        b_we      = lat_we;
        b_addr    = lat_off;
        b_wdata   = lat_wd;
        loc_we    = 1'b0;
        bad_wr    = 1'b0;
        bad_burst = 1'b0;
        for (int i = 0; i < NB; i++) begin
            b_sel[i] = (state_q == ST_BANK_WAIT) && (lat_bank == BIW'(i));
        end
        if (state_q == ST_IDLE && s_write) begin
            if (!burst_ok) begin
                bad_burst = 1'b1;
            end else if (tgt == TGT_LOCAL) begin
                loc_we = loc_wr_ok;
                bad_wr = !loc_wr_ok;
            end else if (tgt == TGT_NONE) begin
                bad_wr = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_hub.sv
module cfg_hub
    import cfg_hub_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 32,
    parameter int BCW     = 4,
    parameter int RGN_W   = 3,
    parameter int NB      = 3,
    parameter int DB_RGN  = 3,
    parameter int LOC_RGN = 7,
    parameter logic [DW-1:0] ID_VALUE = 32'h5A1E_0001,
    localparam int WA     = AW - 2,
    localparam int OFF_W  = WA - RGN_W,
    localparam int BIW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         s_addr,
    input  logic                  s_read,
    input  logic                  s_write,
    input  logic [DW-1:0]         s_wdata,
    input  logic [BCW-1:0]        s_burst,
    output logic                  s_waitreq,
    output logic [DW-1:0]         s_rdata,
    output logic                  s_rvalid,
    output logic                  irq,
    input  logic [NUM_EXT_EV-1:0] ev_in,
    output logic [NB-1:0]         b_sel,
    output logic                  b_we,
    output logic [OFF_W-1:0]      b_addr,
    output logic [DW-1:0]         b_wdata,
    input  logic [NB*DW-1:0]      b_rdata,
    input  logic [NB-1:0]         b_done
);
    hub_tgt_e          tgt;
    logic [BIW-1:0]    dec_bank;
    logic [OFF_W-1:0]  dec_off;
    logic [DW-1:0]     loc_rdata;
    logic              loc_wr_ok;
    logic              loc_we;
    logic              bad_wr;
    logic              bad_burst;
    logic [NUM_EV-1:0] sts_q;
    logic [NUM_EV-1:0] en_q;
    logic [NUM_EV-1:0] sts_clr;
    logic              unused_lo_bits;

    assign unused_lo_bits = ^s_addr[1:0];

    cfg_hub_decode #(
        .WA(WA), .RGN_W(RGN_W), .NB(NB), .DB_RGN(DB_RGN), .LOC_RGN(LOC_RGN)
    ) u_decode (
        .word_addr (s_addr[AW-1:2]),
        .tgt       (tgt),
        .bank_idx  (dec_bank),
        .offset    (dec_off)
    );

    cfg_hub_events #(
        .DW(DW), .OFF_W(OFF_W), .ID_VALUE(ID_VALUE)
    ) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_in         (ev_in),
        .set_bad_wr    (bad_wr),
        .set_bad_burst (bad_burst),
        .loc_we        (loc_we),
        .loc_off       (dec_off),
        .loc_wdata     (s_wdata[NUM_EV-1:0]),
        .loc_rdata     (loc_rdata),
        .loc_wr_ok     (loc_wr_ok),
        .sts_q         (sts_q),
        .en_q          (en_q),
        .sts_clr       (sts_clr),
        .irq           (irq)
    );

    cfg_hub_fsm #(
        .DW(DW), .NB(NB), .OFF_W(OFF_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_read    (s_read),
        .s_write   (s_write),
        .s_wdata   (s_wdata),
        .burst_ok  (s_burst == BCW'(1)),
        .tgt       (tgt),
        .dec_bank  (dec_bank),
        .dec_off   (dec_off),
        .loc_rdata (loc_rdata),
        .loc_wr_ok (loc_wr_ok),
        .b_done    (b_done),
        .b_rdata   (b_rdata),
        .s_waitreq (s_waitreq),
        .s_rvalid  (s_rvalid),
        .s_rdata   (s_rdata),
        .b_sel     (b_sel),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .b_wdata   (b_wdata),
        .loc_we    (loc_we),
        .bad_wr    (bad_wr),
        .bad_burst (bad_burst)
    );
endmodule

// File: rtl/cfg_hub_chk.sv
module cfg_hub_chk #(
    parameter int NB  = 3,
    parameter int NEV = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NB-1:0]  b_sel,
    input logic           s_waitreq,
    input logic           s_rvalid,
    input logic           irq,
    input logic [NEV-1:0] sts,
    input logic [NEV-1:0] en,
    input logic [NEV-1:0] clr
);
    a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_sel));

    a_r3_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (|b_sel) |-> s_waitreq);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |=> !s_rvalid);

    a_r3_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> $past(!s_waitreq));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts & $past(sts & ~clr)) == $past(sts & ~clr)));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0));

    a_r10_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !s_waitreq |-> (b_sel == '0));
endmodule

bind cfg_hub cfg_hub_chk #(.NB(NB), .NEV(cfg_hub_pkg::NUM_EV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .b_sel     (b_sel),
    .s_waitreq (s_waitreq),
    .s_rvalid  (s_rvalid),
    .irq       (irq),
    .sts       (sts_q),
    .en        (en_q),
    .clr       (sts_clr)
);

// File: tb/test_cfg_hub.sv
`timescale 1ns/1ps
module test_cfg_hub;
    localparam int NB = 3;
    localparam logic [31:0] ID = 32'h5A1E_0001;
    localparam logic [16:0] A_STS = 17'h1C000;
    localparam logic [16:0] A_EN  = 17'h1C004;
    localparam logic [16:0] A_ID  = 17'h1C008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] s_addr = '0;
    logic        s_read = 1'b0;
    logic        s_write = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_burst = 4'd1;
    logic        s_waitreq;
    logic [31:0] s_rdata;
    logic        s_rvalid;
    logic        irq;
    logic [2:0]  ev_in = '0;
    logic [NB-1:0] b_sel;
    logic        b_we;
    logic [11:0] b_addr;
    logic [31:0] b_wdata;
    logic [NB*32-1:0] b_rdata;
    logic [NB-1:0] b_done;

    int checks = 0;
    int fails = 0;
    int sel_cycles = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    cfg_hub i_cfg_hub (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_read(s_read),
        .s_write(s_write), .s_wdata(s_wdata), .s_burst(s_burst),
        .s_waitreq(s_waitreq), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
        .irq(irq), .ev_in(ev_in), .b_sel(b_sel), .b_we(b_we),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_done(b_done)
    );

    // bank models: bank k raises done after k+1 selected cycles
    logic [31:0] mem [NB][4];
    int          bcnt [NB];

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            b_done[k] = b_sel[k] && (bcnt[k] == k + 1);
            b_rdata[k*32 +: 32] = mem[k][b_addr[1:0]];
        end
    end

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (|b_sel) sel_cycles <= sel_cycles + 1;
        for (int k = 0; k < NB; k++) begin
            if (!rst_n) begin
                bcnt[k] <= 0;
                for (int w = 0; w < 4; w++) mem[k][w] <= '0;
            end else if (b_sel[k]) begin
                bcnt[k] <= bcnt[k] + 1;
                if (b_done[k] && b_we) mem[k][b_addr[1:0]] <= b_wdata;
            end else begin
                bcnt[k] <= 0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic access(input logic we, input logic [16:0] a, input logic [31:0] d,
                          input logic [3:0] bc, output logic [31:0] rd, output int waits);
        s_addr = a; s_write = we; s_read = !we; s_wdata = d; s_burst = bc;
        waits = 0;
        for (int g = 0; g < 50; g++) begin
            if (!s_waitreq) break;
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        s_read = 1'b0; s_write = 1'b0; s_burst = 4'd1;
        rd = s_rdata;
        check(we ? "R3 no rvalid on write" : "R3 rvalid pulse", 32'(s_rvalid), 32'(!we));
        @(negedge clk);
        check("R3 rvalid single", 32'(s_rvalid), 32'd0);
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        logic [31:0] r; int w;
        access(1'b1, a, d, 4'd1, r, w);
    endtask

    task automatic rd_chk(input string req, input logic [16:0] a, input logic [31:0] exp);
        logic [31:0] r; int w;
        access(1'b0, a, 32'h0, 4'd1, r, w);
        check(req, r, exp);
    endtask

    task automatic pulse_ev(input logic [2:0] e);
        ev_in = e;
        @(negedge clk);
        ev_in = '0;
        @(negedge clk);
    endtask

    // {we, addr17, wdata32, burst4, exp_rdata32, waits8}
    localparam int NV = 11;
    localparam logic [93:0] VEC [NV] = '{
        {1'b1, 17'h00004, 32'hAA000001, 4'd1, 32'h0,        8'd3}, // R2 bank0 w1
        {1'b1, 17'h04008, 32'hBB000002, 4'd1, 32'h0,        8'd4}, // R2 bank1 w2
        {1'b1, 17'h0800F, 32'hCC000003, 4'd1, 32'h0,        8'd5}, // R1 bank2 w3
        {1'b1, 17'h00000, 32'h11111111, 4'd1, 32'h0,        8'd3}, // R2 bank0 w0
        {1'b0, 17'h00006, 32'h0,        4'd1, 32'hAA000001, 8'd3}, // R1
        {1'b0, 17'h0400A, 32'h0,        4'd1, 32'hBB000002, 8'd4}, // R3
        {1'b0, 17'h0800C, 32'h0,        4'd1, 32'hCC000003, 8'd5}, // R3
        {1'b0, 17'h00001, 32'h0,        4'd1, 32'h11111111, 8'd3}, // R1
        {1'b0, 17'h10000, 32'h0,        4'd1, 32'h0,        8'd1}, // R5
        {1'b0, 17'h0C000, 32'h0,        4'd1, 32'h0,        8'd1}, // R4
        {1'b0, A_ID,      32'h0,        4'd1, ID,           8'd1}  // R5
    };

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int w;
        int sc;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 irq", 32'(irq), 32'd0);
        check("R10 rvalid", 32'(s_rvalid), 32'd0);
        check("R10 sel", 32'(b_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 waitreq idle", 32'(s_waitreq), 32'd1);
        rd_chk("R10 status", A_STS, 32'd0);
        rd_chk("R10 enable", A_EN, 32'd0);

        // vector table: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            sc = sel_cycles;
            access(VEC[i][93], VEC[i][92:76], VEC[i][75:44], VEC[i][43:40], r, w);
            check("R3 wait cycles", 32'(w), 32'(VEC[i][7:0]));
            if (!VEC[i][93]) check("R2 read data", r, VEC[i][39:8]);
            if (VEC[i][7:0] == 8'd1) check("R4 no bank select", 32'(sel_cycles - sc), 32'd0);
        end
        rd_chk("R5 valid accesses leave status", A_STS, 32'd0);

        // R7 sticky events, R9 masked
        pulse_ev(3'b001);
        repeat (3) @(negedge clk);
        rd_chk("R7 port-write bit", A_STS, 32'h01);
        check("R9 disabled irq low", 32'(irq), 32'd0);
        pulse_ev(3'b010);
        pulse_ev(3'b100);
        rd_chk("R7 oob bits", A_STS, 32'h07);

        // R9 enable
        wr(A_EN, 32'h01);
        check("R9 irq enabled", 32'(irq), 32'd1);
        // R8 clear
        wr(A_STS, 32'h01);
        check("R9 irq after clear", 32'(irq), 32'd0);
        rd_chk("R8 w1c", A_STS, 32'h06);
        // R8 event wins over same-cycle clear
        ev_in = 3'b001;
        fork
            wr(A_STS, 32'h07);
            begin @(posedge clk); @(negedge clk); ev_in = '0; end
        join
        rd_chk("R8 set beats clear", A_STS, 32'h01);
        wr(A_STS, 32'h01);
        rd_chk("R8 cleared", A_STS, 32'h00);

        // R6 bad burst
        access(1'b1, 17'h00000, 32'hDEAD0000, 4'd2, r, w);
        check("R6 not forwarded waits", 32'(w), 32'd1);
        rd_chk("R6 target unchanged", 17'h00000, 32'h11111111);
        rd_chk("R6 status bit4", A_STS, 32'h10);
        check("R9 bit4 disabled", 32'(irq), 32'd0);
        wr(A_EN, 32'h10);
        check("R9 bit4 enabled", 32'(irq), 32'd1);
        wr(A_STS, 32'h10);
        check("R9 irq dropped", 32'(irq), 32'd0);

        // R5 unmapped write
        wr(17'h14008, 32'h5);
        rd_chk("R5 unmapped write", A_STS, 32'h08);
        wr(A_STS, 32'h08);
        // R5 read-only identity
        wr(A_ID, 32'hFFFFFFFF);
        rd_chk("R5 ro write flagged", A_STS, 32'h08);
        rd_chk("R5 id unchanged", A_ID, ID);
        wr(A_STS, 32'h08);
        // R5 local offset above 2
        wr(17'h1C00C, 32'h3);
        rd_chk("R5 local hole write", A_STS, 32'h08);
        rd_chk("R5 local hole read", 17'h1C00C, 32'h0);
        wr(A_STS, 32'h08);
        // R4 doorbell write
        sc = sel_cycles;
        wr(17'h0C004, 32'h77);
        check("R4 doorbell write not forwarded", 32'(sel_cycles - sc), 32'd0);
        rd_chk("R4 doorbell write flagged", A_STS, 32'h08);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule